// File: doc/BRIEF.md
# Banked Effective Address Generator

This block turns an addressing-mode code, up to three operand bytes and a snapshot of the CPU's address registers into a 24-bit effective address. The registers are the direct-page base, the data bank, the program bank, the program counter, the stack pointer and the two index registers. Direct, absolute, stack-relative, program-relative and indexed modes need no memory traffic. They finish two clock edges after the start strobe.

Indirect modes first read a 2-byte or 3-byte pointer from bank 0. They use a byte-wide request/valid port to do this, then add the bank and any index. The result comes with a single-cycle done pulse. A page-crossed flag goes with it, which the cycle accounting logic uses to charge an extra cycle when indexing moves the address into another 256-byte page.

Top module: `ea_gen`

## Requirements
- R1: After reset, `done`, `busy`, `memReq` and `pageCrossed` are low and `effAddr` is zero.
- R2: Mode 0 gives {0x00, D + op[7:0]} and mode 10 gives {0x00, S + op[7:0]}. Both sums wrap in 16 bits. Neither mode raises `memReq`, and `done` goes high two rising edges after the edge that samples `start`.
- R3: Mode 1 gives {DBR, op[15:0]}. Mode 2 gives op[23:0] unchanged.
- R4: Mode 3 gives {0x00, D + op[7:0] + X} and mode 4 gives {0x00, D + op[7:0] + Y}. The sum wraps in 16 bits, so the bank is always 0.
- R5: Indirect modes read pointer bytes low byte first, at consecutive addresses {0x00, base + k}, with k counting up from 0. The 16-bit part wraps inside bank 0. `memReq` and `memAddr` stay unchanged until `memValid` is high at a rising edge, and exactly 2 bytes are read, or 3 for modes 6 and 9.
- R6: Mode 5 reads a pointer at D + op[7:0] and gives {DBR, ptr16}. Mode 6 reads 3 bytes there and gives {byte2, ptr16}. Mode 7 reads a 2-byte pointer at D + op[7:0] + X and gives {DBR, ptr16}.
- R7: Mode 8 gives {DBR, ptr16} + Y. Mode 9 gives {byte2, ptr16} + Y, using a pointer at D + op[7:0]. Mode 11 reads a 2-byte pointer at S + op[7:0] and gives {DBR, ptr16} + Y. All of these sums wrap modulo 2^24.
- R8: Mode 12 gives {PBR, PC + signext(op[7:0])} and mode 13 gives {PBR, PC + op[15:0]}. Both sums wrap in 16 bits.
- R9: Mode 14 gives {DBR, op[15:0]} + X and mode 15 gives {DBR, op[15:0]} + Y, modulo 2^24.
- R10: `pageCrossed` is high only in a `done` cycle. It is high only in modes 8, 9, 11, 14 and 15, and only when bits 15:8 of the base address before indexing differ from bits 15:8 of the result.
- R11: `done` lasts one cycle. A `start` that arrives while `busy` is high is ignored and produces no extra result. For indirect modes, `done` rises two edges after the edge that accepts the last pointer byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a calculation (sampled while idle) |
| mode | input | 4 | Addressing-mode code |
| operand | input | 24 | Operand bytes, low byte in bits 7:0 |
| regD | input | 16 | Direct-page base |
| regDbr | input | 8 | Data bank |
| regPbr | input | 8 | Program bank |
| regPc | input | 16 | Program counter |
| regS | input | 16 | Stack pointer |
| regX | input | 16 | X index |
| regY | input | 16 | Y index |
| memReq | output | 1 | Pointer byte read request |
| memAddr | output | 24 | Pointer byte address |
| memRdata | input | 8 | Returned byte |
| memValid | input | 1 | Returned byte is valid |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | Result valid pulse |
| effAddr | output | 24 | Effective address |
| pageCrossed | output | 1 | Indexing crossed a 256-byte page |

## Verification
A wrong byte counter or pointer base shows up at the ports as a wrong memory address. The bench's memory returns data that depends on the address, so the final address also comes out wrong within the same operation, and the number of handshakes differs from the expected count. A state machine that leaves idle too early or stays busy too long shows up as a missing, duplicated or stretched `done` pulse on the next operation. A wrong capture of the base address before indexing shows up as a wrong `pageCrossed` in the cycle where `done` is high.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int ADDR_W  = 24;
  localparam int WORD_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int PTR_MAX = 3;
  localparam int IDX_W   = $clog2(PTR_MAX);

  typedef enum logic [3:0] {
    M_DIRECT = 4'd0, M_ABS = 4'd1, M_ABS_LONG = 4'd2, M_DIR_X = 4'd3,
    M_DIR_Y = 4'd4, M_DIR_IND = 4'd5, M_DIR_IND_LONG = 4'd6, M_DIR_X_IND = 4'd7,
    M_DIR_IND_Y = 4'd8, M_DIR_IND_LONG_Y = 4'd9, M_STACK = 4'd10,
    M_STACK_IND_Y = 4'd11, M_PC_REL8 = 4'd12, M_PC_REL16 = 4'd13,
    M_ABS_X = 4'd14, M_ABS_Y = 4'd15
  } modeT;

  typedef struct packed {
    logic             load;     // capture inputs
    logic             capture;  // store returned pointer byte
    logic [IDX_W-1:0] byteIdx;  // current pointer byte
    logic             finish;   // form final address
  } strobeT;

  function automatic logic isIndirect(modeT m);
    return m inside {M_DIR_IND, M_DIR_IND_LONG, M_DIR_X_IND, M_DIR_IND_Y,
                     M_DIR_IND_LONG_Y, M_STACK_IND_Y};
  endfunction

  function automatic logic isLong(modeT m);
    return m inside {M_DIR_IND_LONG, M_DIR_IND_LONG_Y};
  endfunction

  function automatic logic isLateIndexed(modeT m);
    return m inside {M_DIR_IND_Y, M_DIR_IND_LONG_Y, M_STACK_IND_Y, M_ABS_X, M_ABS_Y};
  endfunction

  function automatic logic [IDX_W-1:0] lastByte(modeT m);
    return isLong(m) ? IDX_W'(PTR_MAX - 1) : IDX_W'(PTR_MAX - 2);
  endfunction
endpackage

// File: rtl/eag_control.sv
module eag_control
  import eag_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  modeT   modeIn,
  input  logic   memValid,
  output strobeT strobe,
  output logic   memReq,
  output logic   busy,
  output logic   done
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_FINISH} stateT;

  stateT            state;
  modeT             curMode;
  logic [IDX_W-1:0] byteCnt;

  always_comb begin
    strobe         = '0;
    strobe.byteIdx = byteCnt;
    strobe.load    = start && (state == S_IDLE);
    strobe.capture = (state == S_FETCH) && memValid;
    strobe.finish  = (state == S_FINISH);
  end

  assign memReq = (state == S_FETCH);
  assign busy   = (state != S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      curMode <= M_DIRECT;
      byteCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= (state == S_FINISH);
      unique case (state)
        S_IDLE: if (start) begin
          curMode <= modeIn;
          byteCnt <= '0;
          state   <= isIndirect(modeIn) ? S_FETCH : S_FINISH;
        end
        S_FETCH: if (memValid) begin
          if (byteCnt == lastByte(curMode)) state <= S_FINISH;
          else byteCnt <= byteCnt + 1'b1;
        end
        S_FINISH: state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  // R11: the result strobe never stretches
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R5: a pending request is held until answered
  p_hold_req_r5: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid |=> memReq);
  // R2: modes without a pointer never touch memory
  p_no_req_direct_r2: assert property (@(posedge clk) disable iff (!rstN)
    busy && !isIndirect(curMode) |-> !memReq);
endmodule

// File: rtl/eag_datapath.sv
module eag_datapath
  import eag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  modeT              modeIn,
  input  logic [ADDR_W-1:0] operand,
  input  logic [WORD_W-1:0] regD,
  input  logic [BYTE_W-1:0] regDbr,
  input  logic [BYTE_W-1:0] regPbr,
  input  logic [WORD_W-1:0] regPc,
  input  logic [WORD_W-1:0] regS,
  input  logic [WORD_W-1:0] regX,
  input  logic [WORD_W-1:0] regY,
  input  logic [BYTE_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] effAddr,
  output logic              pageCrossed
);
  localparam int BANK_W = ADDR_W - WORD_W;

  modeT              modeQ;
  logic [ADDR_W-1:0] opQ;
  logic [WORD_W-1:0] dQ, pcQ, sQ, xQ, yQ;
  logic [BYTE_W-1:0] dbrQ, pbrQ;
  logic [BYTE_W-1:0] ptrQ [PTR_MAX];

  logic [WORD_W-1:0] dirAddr, stackAddr, ptrBase, ptrWord, indexVal;
  logic [BYTE_W-1:0] ptrBank;
  logic [ADDR_W-1:0] baseAddr, indexedAddr, finalAddr;
  logic              crossNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= M_DIRECT; opQ <= '0; dQ <= '0; pcQ <= '0; sQ <= '0;
      xQ <= '0; yQ <= '0; dbrQ <= '0; pbrQ <= '0;
    end else if (strobe.load) begin
      modeQ <= modeIn; opQ <= operand; dQ <= regD; pcQ <= regPc; sQ <= regS;
      xQ <= regX; yQ <= regY; dbrQ <= regDbr; pbrQ <= regPbr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PTR_MAX; i++) ptrQ[i] <= '0;
    end else if (strobe.capture) begin
      for (int i = 0; i < PTR_MAX; i++)
        if (strobe.byteIdx == IDX_W'(i)) ptrQ[i] <= memRdata;
    end
  end

  assign dirAddr   = dQ + WORD_W'(opQ[BYTE_W-1:0]);
  assign stackAddr = sQ + WORD_W'(opQ[BYTE_W-1:0]);

  always_comb begin
    unique case (modeQ)
      M_DIR_X_IND:   ptrBase = dirAddr + xQ;
      M_STACK_IND_Y: ptrBase = stackAddr;
      default:       ptrBase = dirAddr;
    endcase
  end

  // pointer bytes always live in bank 0, wrapping inside it
  assign memAddr  = {BANK_W'(0), ptrBase + WORD_W'(strobe.byteIdx)};
  assign ptrWord  = {ptrQ[1], ptrQ[0]};
  assign ptrBank  = isLong(modeQ) ? ptrQ[PTR_MAX-1] : dbrQ;
  assign indexVal = (modeQ == M_ABS_X) ? xQ : yQ;

  always_comb begin
    if (modeQ inside {M_ABS_X, M_ABS_Y}) baseAddr = {dbrQ, opQ[WORD_W-1:0]};
    else                                 baseAddr = {ptrBank, ptrWord};
  end

  assign indexedAddr = baseAddr + ADDR_W'(indexVal);
  assign crossNow    = isLateIndexed(modeQ) &&
                       (baseAddr[WORD_W-1:BYTE_W] != indexedAddr[WORD_W-1:BYTE_W]);

  always_comb begin
    unique case (modeQ)
      M_DIRECT:   finalAddr = {BANK_W'(0), dirAddr};
      M_ABS:      finalAddr = {dbrQ, opQ[WORD_W-1:0]};
      M_ABS_LONG: finalAddr = opQ;
      M_DIR_X:    finalAddr = {BANK_W'(0), dirAddr + xQ};
      M_DIR_Y:    finalAddr = {BANK_W'(0), dirAddr + yQ};
      M_DIR_IND, M_DIR_IND_LONG, M_DIR_X_IND:
                  finalAddr = {ptrBank, ptrWord};
      M_STACK:    finalAddr = {BANK_W'(0), stackAddr};
      M_PC_REL8:  finalAddr = {pbrQ, pcQ + {{(WORD_W-BYTE_W){opQ[BYTE_W-1]}}, opQ[BYTE_W-1:0]}};
      M_PC_REL16: finalAddr = {pbrQ, pcQ + opQ[WORD_W-1:0]};
      default:    finalAddr = indexedAddr;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      effAddr     <= '0;
      pageCrossed <= 1'b0;
    end else begin
      pageCrossed <= strobe.finish && crossNow;
      if (strobe.finish) effAddr <= finalAddr;
    end
  end

  // R10: the flag only ever belongs to a mode that indexes after the base
  p_flag_mode_r10: assert property (@(posedge clk) disable iff (!rstN)
    pageCrossed |-> isLateIndexed(modeQ));
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import eag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [3:0]  mode,
  input  logic [23:0] operand,
  input  logic [15:0] regD,
  input  logic [7:0]  regDbr,
  input  logic [7:0]  regPbr,
  input  logic [15:0] regPc,
  input  logic [15:0] regS,
  input  logic [15:0] regX,
  input  logic [15:0] regY,
  output logic        memReq,
  output logic [23:0] memAddr,
  input  logic [7:0]  memRdata,
  input  logic        memValid,
  output logic        busy,
  output logic        done,
  output logic [23:0] effAddr,
  output logic        pageCrossed
);
  strobeT strobe;
  modeT   modeSel;

  assign modeSel = modeT'(mode);

  eag_control u_control (
    .clk(clk), .rstN(rstN), .start(start), .modeIn(modeSel),
    .memValid(memValid), .strobe(strobe), .memReq(memReq),
    .busy(busy), .done(done)
  );

  eag_datapath u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .modeIn(modeSel),
    .operand(operand), .regD(regD), .regDbr(regDbr), .regPbr(regPbr),
    .regPc(regPc), .regS(regS), .regX(regX), .regY(regY),
    .memRdata(memRdata), .memAddr(memAddr), .effAddr(effAddr),
    .pageCrossed(pageCrossed)
  );

  // R5: address of a pending pointer read does not move
  p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid |=> $stable(memAddr));
  // R10: flag appears only together with the result strobe
  p_flag_with_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    pageCrossed |-> done);
endmodule

// File: tb/tb_ea_gen.sv
module tb_ea_gen;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, start, memReq, memValid, busy, done, pageCrossed;
  logic [3:0]  mode;
  logic [23:0] operand, memAddr, effAddr;
  logic [15:0] regD, regPc, regS, regX, regY;
  logic [7:0]  regDbr, regPbr, memRdata;

  ea_gen dut (.*);

  int nChecks = 0, nFails = 0, reqCount = 0, memLat = 0, waitCnt = 0;
  bit prevDone = 0;
  logic [23:0] qAddr[$];
  bit          qFlag[$];
  int          qReq[$];
  string       qTag[$];

  function automatic logic [7:0] memByte(logic [23:0] a);
    return (a[7:0] ^ 8'hA5) + a[15:8];
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic expectOp(input logic [3:0] m, input logic [23:0] op,
                          output logic [23:0] ea, output bit pc, output int nReq);
    logic [15:0] dp, sr, pb;
    logic [23:0] base;
    logic [7:0]  bk;
    int          len;
    bit          late;
    dp = regD + {8'h00, op[7:0]};
    sr = regS + {8'h00, op[7:0]};
    late = 0; nReq = 0; base = '0;
    case (m)
      4'd0:  ea = {8'h00, dp};
      4'd1:  ea = {regDbr, op[15:0]};
      4'd2:  ea = op;
      4'd3:  ea = {8'h00, dp + regX};
      4'd4:  ea = {8'h00, dp + regY};
      4'd10: ea = {8'h00, sr};
      4'd12: ea = {regPbr, regPc + {{8{op[7]}}, op[7:0]}};
      4'd13: ea = {regPbr, regPc + op[15:0]};
      4'd14, 4'd15: begin
        base = {regDbr, op[15:0]};
        ea = base + {8'h00, (m == 4'd14) ? regX : regY};
        late = 1;
      end
      default: begin
        pb  = (m == 4'd7) ? dp + regX : (m == 4'd11) ? sr : dp;
        len = (m == 4'd6 || m == 4'd9) ? 3 : 2;
        bk  = (len == 3) ? memByte({8'h00, pb + 16'd2}) : regDbr;
        base = {bk, memByte({8'h00, pb + 16'd1}), memByte({8'h00, pb})};
        nReq = len;
        if (m == 4'd8 || m == 4'd9 || m == 4'd11) begin
          ea = base + {8'h00, regY};
          late = 1;
        end else ea = base;
      end
    endcase
    pc = late && (base[15:8] != ea[15:8]);
  endtask

  task automatic issue(input logic [3:0] m, input logic [23:0] op, input string tag);
    logic [23:0] ea; bit pc; int n;
    @(negedge clk);
    while (busy) @(negedge clk);
    expectOp(m, op, ea, pc, n);
    qAddr.push_back(ea); qFlag.push_back(pc); qReq.push_back(n); qTag.push_back(tag);
    mode = m; operand = op; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runOp(input logic [3:0] m, input logic [23:0] op, input string tag);
    issue(m, op, tag);
    while (busy) @(negedge clk);
  endtask

  // memory responder: data is a function of address
  initial begin
    memValid = 1'b0; memRdata = '0;
    forever begin
      @(negedge clk);
      if (memReq && !memValid) begin
        if (waitCnt >= memLat) begin
          memValid = 1'b1; memRdata = memByte(memAddr); waitCnt = 0; reqCount++;
        end else waitCnt++;
      end else memValid = 1'b0;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (done && prevDone) check(0, "R11", "done stretched", 1, 0);
      if (pageCrossed && !done) check(0, "R10", "flag without done", 1, 0);
      if (done) begin
        if (qAddr.size() == 0) check(0, "R11", "unexpected result", effAddr, 0);
        else begin
          string t;
          t = qTag.pop_front();
          check(effAddr == qAddr[0], t, "effAddr", effAddr, qAddr[0]);
          check(pageCrossed == qFlag[0], {t, "/R10"}, "pageCrossed", pageCrossed, qFlag[0]);
          check(reqCount == qReq[0], {t, "/R5"}, "pointer reads", reqCount, qReq[0]);
          void'(qAddr.pop_front()); void'(qFlag.pop_front()); void'(qReq.pop_front());
        end
        reqCount = 0;
      end
      prevDone = done;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; mode = '0; operand = '0;
    regD = 16'h1234; regDbr = 8'h7E; regPbr = 8'h12; regPc = 16'h8000;
    regS = 16'h01F0; regX = 16'h0090; regY = 16'h0123;
    repeat (3) @(negedge clk);
    check(!done && !busy && !memReq && !pageCrossed && effAddr == 0, "R1", "reset outputs",
          {done, busy, memReq, pageCrossed}, 0);
    rstN = 1'b1;
    check(effAddr == 0, "R1", "effAddr after reset", effAddr, 0);

    runOp(4'd0,  24'h000056, "R2");
    regD = 16'hFFF0;
    runOp(4'd0,  24'h000020, "R2");      // wraps in bank 0
    runOp(4'd10, 24'h000011, "R2");
    runOp(4'd1,  24'h001234, "R3");
    runOp(4'd2,  24'hABCDEF, "R3");
    regD = 16'hFF00;
    runOp(4'd3,  24'h0000F0, "R4");      // wraps to low bank-0 addresses
    runOp(4'd4,  24'h000010, "R4");

    regD = 16'h2000; memLat = 0;
    runOp(4'd5,  24'h000040, "R6");
    memLat = 3;
    runOp(4'd6,  24'h000044, "R6");
    regD = 16'hFFFF;
    runOp(4'd5,  24'h000000, "R5");      // pointer straddles bank-0 wrap
    regD = 16'h3000; memLat = 1;
    runOp(4'd7,  24'h000020, "R6");
    runOp(4'd8,  24'h000010, "R7");
    regY = 16'hFFF0;
    runOp(4'd9,  24'h000031, "R7");
    runOp(4'd11, 24'h000005, "R7");

    regPc = 16'h0010;
    runOp(4'd12, 24'h0000E0, "R8");      // negative displacement wraps
    regPc = 16'hF000;
    runOp(4'd13, 24'h002000, "R8");
    regPc = 16'h1000;
    runOp(4'd12, 24'h00007F, "R8");

    regX = 16'h0090;
    runOp(4'd14, 24'h0012F0, "R9");      // page crossed
    regY = 16'h0005;
    runOp(4'd15, 24'h001210, "R9");      // same page
    regDbr = 8'hFF; regX = 16'h0002;
    runOp(4'd14, 24'h00FFFF, "R9");      // carry out of 24 bits

    // start while busy is ignored
    regDbr = 8'h40; memLat = 4;
    issue(4'd9, 24'h000060, "R11");
    @(negedge clk);
    mode = 4'd1; operand = 24'h00BEEF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    check(qAddr.size() == 0, "R11", "pending results", qAddr.size(), 0);
    check(!busy && !done, "R11", "idle after ignored start", {busy, done}, 0);

    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule